// File: doc/BRIEF.md
# Dual-Bank Parallel I/O Controller

This peripheral provides 48 general-purpose lines behind an 8-byte register window on a simple byte-wide host bus. The lines form two identical banks. Each bank has three 8-bit ports and one write-only configuration register. The configuration word sets the direction of each port. The third port splits into two 4-bit halves, and each half has its own direction bit.

On the pin side, every line has an output value, an output enable and an input level. Software first writes a bank's configuration word. It then loads the output latches through the port offsets and reads the line levels back through the same offsets. Input levels pass through a two-stage synchronizer before they can be read. A read returns its data in the cycle after the read strobe.

Top module: `dual_pio`

## Requirements
- R1: After synchronous reset, every line is an input (`pin_oe` all 0), every output latch is 0 (`pin_out` all 0) and `bus_rdata` is 0.
- R2: The address map is as follows. Offsets 0, 1 and 2 are ports A, B and C of bank 0, and offset 3 is the bank 0 configuration register. Offsets 4 to 7 are the same registers for bank 1. Line index = bank*24 + port*8 + bit, with port A=0, B=1, C=2.
- R3: A configuration write with bit 7 = 1 sets the directions on the next clock edge. Bit 4 controls port A and bit 1 controls port B. In each case 1 means input (`pin_oe` 0) and 0 means output (`pin_oe` 1).
- R4: In a configuration word, bit 3 sets the direction of port C lines 7..4 and bit 0 sets the direction of port C lines 3..0, again with 1 meaning input. The two halves are set independently.
- R5: Writing 0x80 to a configuration register makes all 24 lines of that bank outputs.
- R6: A configuration write with bit 7 = 0 changes neither the directions nor the output latches.
- R7: A configuration write with bit 7 = 1 clears all three output latches of that bank to 0.
- R8: A write to a port offset loads that port's 8-bit latch. The latch appears on `pin_out` for all eight lines, the lines enabled as outputs drive it, and the write leaves the directions unchanged.
- R9: A read of a port offset returns the input-line levels sampled through a two-flop synchronizer. The byte appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R10: In a port read, each line that is configured as an output returns its latch bit instead of the pin level.
- R11: A read of either configuration offset returns 0xFF.
- R12: The two banks are independent. Writes to one bank change no direction or latch of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset in the window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_out | output | 48 | Output latch value per line |
| pin_oe | output | 48 | Output enable per line, 1 = driving |
| pin_in | input | 48 | Input level per line |

## Verification
The embedded assertions check the following on every cycle:
- the reset state;
- that directions and latches stay unchanged after an unarmed configuration write;
- that latches clear after an armed configuration write;
- that port writes do not disturb directions;
- that the synchronizer stages are ordered correctly;
- the 0xFF readback of the configuration offsets.

Only the bench scenarios can show the remaining behaviour. This covers the correct bit-to-port mapping of the configuration word, the mixed readback of a half-input port C, the independence of the two banks, and agreement with a reference model over random command streams.

// File: rtl/dpio_pkg.sv
package dpio_pkg;
    localparam int PORT_W    = 8;
    localparam int NIB_W     = PORT_W / 2;
    localparam int PORTS     = 3;
    localparam int BANK_W    = PORTS * PORT_W;
    localparam int NUM_BANKS = 2;
    localparam int LINES     = NUM_BANKS * BANK_W;
    localparam int ADDR_W    = 3;
    localparam int SEL_W     = 2;

    localparam int ARM_BIT   = 7;
    localparam int A_BIT     = 4;
    localparam int B_BIT     = 1;
    localparam int CHI_BIT   = 3;
    localparam int CLO_BIT   = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_t;

    // 1 = input for each field
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } bank_dir_t;

    localparam bank_dir_t DIR_ALL_IN = '{a_in: 1'b1, b_in: 1'b1, chi_in: 1'b1, clo_in: 1'b1};

    function automatic bank_dir_t decode_ctrl(input logic [PORT_W-1:0] w);
        bank_dir_t d;
        d.a_in   = w[A_BIT];
        d.b_in   = w[B_BIT];
        d.chi_in = w[CHI_BIT];
        d.clo_in = w[CLO_BIT];
        return d;
    endfunction

    function automatic logic [BANK_W-1:0] dir_to_oe(input bank_dir_t d);
        return {{NIB_W{~d.chi_in}}, {NIB_W{~d.clo_in}},
                {PORT_W{~d.b_in}}, {PORT_W{~d.a_in}}};
    endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    // R9: first stage captures the pin one edge later
    assert_sync_stage1_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stage1_q == $past(d));
    // R9: second stage follows the first by one edge
    assert_sync_stage2_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stage2_q == $past(stage1_q));
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import dpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PORT_W-1:0] wdata,
    input  logic [BANK_W-1:0] pin_sync,
    output logic [BANK_W-1:0] pin_out,
    output logic [BANK_W-1:0] pin_oe,
    output logic [PORT_W-1:0] rd_byte
);
    bank_dir_t dir_q;
    logic [PORTS-1:0][PORT_W-1:0] latch_q;
    logic [PORTS-1:0][PORT_W-1:0] mixed;
    logic ctrl_wr;
    logic ctrl_arm;

    assign ctrl_wr  = wr_en && (reg_sel_t'(sel) == SEL_CTRL);
    assign ctrl_arm = ctrl_wr && wdata[ARM_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            dir_q <= DIR_ALL_IN;
        else if (ctrl_arm)
            dir_q <= decode_ctrl(wdata);
    end

    assign pin_oe = dir_to_oe(dir_q);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)
                latch_q[p] <= '0;
            else if (ctrl_arm)
                latch_q[p] <= '0;
            else if (wr_en && sel == SEL_W'(p))
                latch_q[p] <= wdata;
        end

        assign pin_out[p*PORT_W +: PORT_W] = latch_q[p];
        assign mixed[p] = (pin_oe[p*PORT_W +: PORT_W] & latch_q[p])
                        | (~pin_oe[p*PORT_W +: PORT_W] & pin_sync[p*PORT_W +: PORT_W]);
    end

    always_comb begin
        if (reg_sel_t'(sel) == SEL_CTRL)
            rd_byte = '1;
        else
            rd_byte = mixed[sel];
    end

    // R1: reset leaves all lines as inputs with cleared latches
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0));
    // R6: unarmed configuration write changes nothing
    assert_unarmed_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wdata[ARM_BIT]) |=> ($stable(pin_oe) && $stable(pin_out)));
    // R7: armed configuration write clears all latches
    assert_arm_clears_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_arm |=> pin_out == '0);
    // R8: port write leaves directions alone
    assert_port_wr_dir_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel_t'(sel) != SEL_CTRL) |=> $stable(pin_oe));
endmodule

// File: rtl/dual_pio.sv
module dual_pio
    import dpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    input  logic [LINES-1:0]  pin_in
);
    localparam int BANK_BIT = ADDR_W - 1;

    logic [LINES-1:0] pin_sync;
    logic [NUM_BANKS-1:0][PORT_W-1:0] bank_rd;
    logic [SEL_W-1:0] sel;

    assign sel = bus_addr[SEL_W-1:0];

    pio_sync #(.W(LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pio_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bus_wr && bus_addr[BANK_BIT] == 1'(b)),
            .sel      (sel),
            .wdata    (bus_wdata),
            .pin_sync (pin_sync[b*BANK_W +: BANK_W]),
            .pin_out  (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe   (pin_oe[b*BANK_W +: BANK_W]),
            .rd_byte  (bank_rd[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= bank_rd[bus_addr[BANK_BIT]];
    end

    // R11: configuration offsets read back as all ones
    assert_ctrl_readback_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_W'(SEL_CTRL)) |=> bus_rdata == 8'hFF);
    // R9: read data holds while no read is issued
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !$past(rst)) |=> $stable(bus_rdata));
endmodule

// File: tb/test_dual_pio.sv
module test_dual_pio;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_out;
    logic [47:0] pin_oe;
    logic [47:0] pin_in = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model: dir bits {a,b,chi,clo}, 1 = input
    logic [3:0] m_dir [2];
    logic [7:0] m_lat [6];

    always #5 clk = ~clk;

    dual_pio i_dual_pio (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    function automatic logic [47:0] exp_oe();
        logic [47:0] r;
        for (int b = 0; b < 2; b++)
            r[b*24 +: 24] = {{4{~m_dir[b][1]}}, {4{~m_dir[b][0]}},
                             {8{~m_dir[b][2]}}, {8{~m_dir[b][3]}}};
        return r;
    endfunction

    function automatic logic [47:0] exp_out();
        logic [47:0] r;
        for (int i = 0; i < 6; i++) r[i*8 +: 8] = m_lat[i];
        return r;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        logic [47:0] oe;
        int idx;
        if (a[1:0] == 2'd3) return 8'hFF;
        oe  = exp_oe();
        idx = a[2] * 3 + a[1:0];
        return (oe[idx*8 +: 8] & m_lat[idx]) | (~oe[idx*8 +: 8] & pin_in[idx*8 +: 8]);
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 2; b++) m_dir[b] = 4'hF;
        for (int i = 0; i < 6; i++) m_lat[i] = 8'h00;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[1:0] == 2'd3) begin
            if (d[7]) begin
                m_dir[a[2]] = {d[4], d[1], d[3], d[0]};
                for (int p = 0; p < 3; p++) m_lat[a[2]*3 + p] = 8'h00;
            end
        end else begin
            m_lat[a[2]*3 + a[1:0]] = d;
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h00C0FFEE));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe", pin_oe, 48'h0);
        chk("R1 out", pin_out, 48'h0);
        chk("R1 rdata", {40'h0, bus_rdata}, 48'h0);

        // R5 / R12: bank 0 all outputs, bank 1 untouched
        bus_write(3'd3, 8'h80);
        chk("R5 all outputs bank0", pin_oe, exp_oe());
        chk("R12 bank1 still inputs", pin_oe[47:24], 24'h0);

        // R8 / R10 port A write and readback of output latch
        bus_write(3'd0, 8'h5A);
        chk("R8 pin_out", pin_out, exp_out());
        pin_in = 48'hFFFF_FFFF_FFA5; settle();
        bus_read(3'd0, rd);
        chk("R10 output reads latch", {40'h0, rd}, 48'h5A);

        // R7: armed write clears latches
        bus_write(3'd1, 8'hC3);
        bus_write(3'd2, 8'h3C);
        bus_write(3'd3, 8'h80);
        chk("R7 latches cleared", pin_out[23:0], 24'h0);

        // R4: port C upper input, lower output (bit3=1, bit0=0)
        bus_write(3'd3, 8'h88);
        chk("R4 nibble oe", {40'h0, pin_oe[23:16]}, 48'h0F);
        bus_write(3'd2, 8'hA5);
        pin_in = 48'h0000_0070_0000; settle();
        bus_read(3'd2, rd);
        chk("R4 mixed C read", {40'h0, rd}, 48'h75);

        // R3: A input, B output
        bus_write(3'd3, 8'h90);
        chk("R3 A in B out", pin_oe, exp_oe());

        // R6: unarmed write ignored
        bus_write(3'd1, 8'h77);
        bus_write(3'd3, 8'h12);
        chk("R6 oe unchanged", pin_oe, exp_oe());
        chk("R6 out unchanged", pin_out, exp_out());

        // R2 / R12: bank 1 port B via offset 5
        bus_write(3'd7, 8'h80);
        bus_write(3'd5, 8'hE1);
        chk("R2 bank1 B line map", {40'h0, pin_out[47:40] ^ pin_out[39:32]}, 48'hE1);
        chk("R12 bank0 kept", pin_out[23:0], exp_out() & 48'hFF_FFFF);

        // R9: input read through synchronizer
        bus_write(3'd7, 8'h9B);
        pin_in = 48'h5A3C_0000_0000; settle();
        bus_read(3'd4, rd);
        chk("R9 input read", {40'h0, rd}, {40'h0, exp_read(3'd4)});

        // R11: configuration readback
        bus_read(3'd3, rd);
        chk("R11 ctrl0 read", {40'h0, rd}, 48'hFF);
        bus_read(3'd7, rd);
        chk("R11 ctrl1 read", {40'h0, rd}, 48'hFF);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] a;
            logic [7:0] d;
            int op;
            pin_in = {$urandom, $urandom};
            settle();
            op = $urandom % 4;
            a  = 3'($urandom);
            d  = 8'($urandom);
            if (op == 0) begin
                a[1:0] = 2'd3;
                bus_write(a, d);
                chk("R3 R6 R7 random ctrl oe", pin_oe, exp_oe());
                chk("R7 random ctrl out", pin_out, exp_out());
            end else if (op == 1) begin
                if (a[1:0] == 2'd3) a[1:0] = 2'd0;
                bus_write(a, d);
                chk("R8 random port write", pin_out, exp_out());
                chk("R8 random oe kept", pin_oe, exp_oe());
            end else begin
                bus_read(a, rd);
                chk("R9 R10 random read", {40'h0, rd}, {40'h0, exp_read(a)});
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule